// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the master side of a shared parallel bus on which the low 16 address bits and the 16 data bits use the same pins, and four extra lines carry the top address bits first and a status nibble afterwards. One accepted request becomes one bus transfer: a read or a write, to memory or to the I/O space. The transfer walks through four time states, T1 to T4. A slow slave can stretch it by holding `ready` low, which adds wait states (Tw) between T3 and T4.

In T1 the sequencer drives the address and the byte-high enable, and pulses the latch strobe so that an external latch can hold the address. From T2 on, the shared lines either float for a read or carry write data. The read and write strobes and the data-enable are driven, and the upper lines switch to status. The tri-state bus is modelled as three vectors: an output value, an output enable and an input value.

Requests use a valid/ready handshake. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is high only when the sequencer is idle or in T4, so a new transfer can follow the last one with no gap. A requester that sees `req_ready` low must hold its request. The response has no back-pressure. `rsp_valid` is a single-cycle pulse, and `rsp_rdata` is valid only while it is high.

Top module: `mux_bus_seq`

## Requirements
- R1: While reset is asserted and in idle, `req_ready`=1, `ale`=0, `rd_n`=`wr_n`=`den_n`=`bhe_n`=1, `ad_oe`=0, `mio`=`dtr`=0, `addr_hi`=0 and `rsp_valid`=0. A reset during a transfer returns the pins to these values.
- R2: In the cycle after a request is accepted (T1), `ale`=1 for exactly that cycle, `ad_oe`=1, `ad_out` equals address bits 15:0, and `bhe_n` equals the requested value, which it keeps through T4.
- R3: `mio`=1 for memory and 0 for I/O. In T1, `addr_hi` carries address bits 19:16 for memory and 0 for I/O.
- R4: `dtr`=1 for a write and 0 for a read. `mio` and `dtr` stay constant from T1 through T4.
- R5: From T2 through T4, including wait states, `addr_hi` carries the status nibble {0,0,mem,write}: bit 1 is the memory flag and bit 0 is the write flag.
- R6: Read: `ad_oe`=0 from T2 through T4. `rd_n`=0 in T2, T3 and every Tw, and 1 in T4. `den_n`=0 from T2 through T4.
- R7: Write: `ad_oe`=1 with `ad_out` equal to the write data from T2 through T4. `wr_n`=0 in T2, T3 and every Tw, and 1 in T4. `den_n`=0 from T2 through T4.
- R8: `ready` is sampled on the edge that ends T3 and on the edge that ends each Tw. Each low sample adds one Tw cycle, whose pins match T3.
- R9: On a read, `ad_in` is captured on the edge where `ready` is sampled high. It is presented on `rsp_rdata` with `rsp_valid`=1 for exactly the T4 cycle.
- R10: `req_ready` is 0 from T1 through the last Tw. A request held during those cycles does not start a transfer. A request accepted in T4 starts T1 on the next cycle.
- R11: `rd_n` and `wr_n` are never low together, and `ale` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bhe_n | input | 1 | Byte-high enable for the transfer, active low |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse (T4) |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| ready | input | 1 | Slave ready; low inserts wait states |
| ale | output | 1 | Address latch strobe |
| mio | output | 1 | Memory (1) or I/O (0) |
| dtr | output | 1 | Transmit (1) or receive (0) |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data path enable, active low |
| bhe_n | output | 1 | Byte-high enable pin, active low |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 16 | Shared address/data lines, received value |
| addr_hi | output | 4 | Upper address bits in T1, status from T2 |

## Verification
T1 pins appear one cycle after the accepting edge. T2 and T3 follow one cycle apart. T4 arrives one cycle after the first edge on which `ready` is high, and `rsp_valid` and `rsp_rdata` appear in that same T4 cycle. The bench drives every input on the falling edge. It then checks each time state on the falling edge of its own cycle, counting the accepting edge and each wait-state edge itself. On wait cycles it gives a wrong value on `ad_in`, so data captured on the wrong edge shows up as a mismatch.

// File: rtl/mux_bus_seq_pkg.sv
package mux_bus_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_state_e;

  // status nibble shown on the upper lines from T2: {zeros, mem, write}
  function automatic logic [3:0] status_code(input logic mem, input logic wr);
    return {2'b00, mem, wr};
  endfunction

endpackage

// File: rtl/mux_bus_seq_fsm.sv
module mux_bus_seq_fsm
  import mux_bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ready,
  output bus_state_e state,
  output logic       capture
);

  bus_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: nxt = start ? ST_T1 : ST_IDLE;
      ST_T1:   nxt = ST_T2;
      ST_T2:   nxt = ST_T3;
      ST_T3,
      ST_TW:   nxt = ready ? ST_T4 : ST_TW;
      ST_T4:   nxt = start ? ST_T1 : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign capture = ((state == ST_T3) || (state == ST_TW)) && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  AST_WAIT_AFTER_LOW_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TW) |-> (!$past(ready) &&
      ($past(state) == ST_T3 || $past(state) == ST_TW))); // R8
  AST_T4_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T4) |-> $past(ready)); // R8
  AST_T1_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T1) |-> $past(start)); // R10

endmodule

// File: rtl/mux_bus_seq_hold.sv
module mux_bus_seq_hold
  import mux_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_state_e        state,
  input  logic              start,
  input  logic              capture,
  input  logic              in_mem,
  input  logic              in_wr,
  input  logic              in_bhe_n,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic              mem_q,
  output logic              wr_q,
  output logic              bhe_n_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q   <= 1'b0;
      wr_q    <= 1'b0;
      bhe_n_q <= 1'b1;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      mem_q   <= in_mem;
      wr_q    <= in_wr;
      bhe_n_q <= in_bhe_n;
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rdata_q <= '0;
    else if (capture && !wr_q)  rdata_q <= bus_in;
  end

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_T2, ST_T3, ST_TW, ST_T4}) |->
      ($stable(mem_q) && $stable(wr_q) && $stable(bhe_n_q) && $stable(wdata_q))); // R4

endmodule

// File: rtl/mux_bus_seq_pins.sv
module mux_bus_seq_pins
  import mux_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_state_e        state,
  input  logic              mem_q,
  input  logic              wr_q,
  input  logic              bhe_n_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic              ale,
  output logic              mio,
  output logic              dtr,
  output logic              rd_n,
  output logic              wr_n,
  output logic              den_n,
  output logic              bhe_n,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   addr_hi
);

  logic in_t1, data_ph, strobe_ph, active;
  logic [3:0] stat;

  assign in_t1     = (state == ST_T1);
  assign data_ph   = state inside {ST_T2, ST_T3, ST_TW, ST_T4};
  assign strobe_ph = state inside {ST_T2, ST_T3, ST_TW};
  assign active    = in_t1 || data_ph;
  assign stat      = status_code(mem_q, wr_q);

  always_comb begin
    ale   = in_t1;
    mio   = active && mem_q;
    dtr   = active && wr_q;
    bhe_n = active ? bhe_n_q : 1'b1;
    rd_n  = !(strobe_ph && !wr_q);
    wr_n  = !(strobe_ph && wr_q);
    den_n = !data_ph;
    ad_oe = in_t1 || (data_ph && wr_q);
    if (in_t1)                 ad_out = addr_q[DATA_W-1:0];
    else if (data_ph && wr_q)  ad_out = wdata_q;
    else                       ad_out = '0;
    if (in_t1)                 addr_hi = mem_q ? addr_q[ADDR_W-1:DATA_W] : '0;
    else if (data_ph)          addr_hi = HI_W'(stat);
    else                       addr_hi = '0;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R11
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R11
  AST_READ_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R6
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (ad_oe && !den_n)); // R7
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && !$past(den_n)) |-> ($stable(dtr) && $stable(mio))); // R4

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_mem,
  input  logic              req_write,
  input  logic              req_bhe_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ready,
  output logic              ale,
  output logic              mio,
  output logic              dtr,
  output logic              rd_n,
  output logic              wr_n,
  output logic              den_n,
  output logic              bhe_n,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [HI_W-1:0]   addr_hi
);

  bus_state_e        state;
  logic              start, capture;
  logic              mem_q, wr_q, bhe_n_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  assign req_ready = (state == ST_IDLE) || (state == ST_T4);
  assign start     = req_valid && req_ready;
  assign rsp_valid = (state == ST_T4);
  assign rsp_rdata = rdata_q;

  mux_bus_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .state(state), .capture(capture)
  );

  mux_bus_seq_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .state(state), .start(start), .capture(capture),
    .in_mem(req_mem), .in_wr(req_write), .in_bhe_n(req_bhe_n),
    .in_addr(req_addr), .in_wdata(req_wdata), .bus_in(ad_in),
    .mem_q(mem_q), .wr_q(wr_q), .bhe_n_q(bhe_n_q),
    .addr_q(addr_q), .wdata_q(wdata_q), .rdata_q(rdata_q)
  );

  mux_bus_seq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .state(state),
    .mem_q(mem_q), .wr_q(wr_q), .bhe_n_q(bhe_n_q),
    .addr_q(addr_q), .wdata_q(wdata_q),
    .ale(ale), .mio(mio), .dtr(dtr), .rd_n(rd_n), .wr_n(wr_n),
    .den_n(den_n), .bhe_n(bhe_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_hi(addr_hi)
  );

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || (!den_n && !rsp_valid)) |-> !req_ready); // R10

endmodule

// File: tb/tb_mux_bus_seq.sv
module tb_mux_bus_seq;

  localparam int CLK_P = 10;

  typedef struct packed {
    logic        mem;
    logic        wr;
    logic        bhe_n;
    logic [19:0] addr;
    logic [15:0] wdata;
    logic [2:0]  nw;
    logic [15:0] rdat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 1'b0, 1'b0, 20'hA5C3E, 16'h0000, 3'd0, 16'h1234},
    '{1'b1, 1'b1, 1'b1, 20'h0F001, 16'hBEEF, 3'd0, 16'h0000},
    '{1'b0, 1'b0, 1'b0, 20'hFA000, 16'h0000, 3'd2, 16'hC0DE},
    '{1'b0, 1'b1, 1'b0, 20'h300FE, 16'h00FF, 3'd1, 16'h0000},
    '{1'b1, 1'b0, 1'b1, 20'hFFFFF, 16'h0000, 3'd3, 16'h8001},
    '{1'b1, 1'b1, 1'b0, 20'h80002, 16'h5A5A, 3'd4, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_mem = 1'b0, req_write = 1'b0, req_bhe_n = 1'b1;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0, ad_in = '0;
  logic ready = 1'b1;
  logic req_ready, rsp_valid, ale, mio, dtr, rd_n, wr_n, den_n, bhe_n, ad_oe;
  logic [15:0] rsp_rdata, ad_out;
  logic [3:0] addr_hi;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  mux_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mem(req_mem), .req_write(req_write), .req_bhe_n(req_bhe_n),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ready(ready), .ale(ale), .mio(mio), .dtr(dtr),
    .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .bhe_n(bhe_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " R1 req_ready"}, req_ready, 1);
    chk({tag, " R1 ale"}, ale, 0);
    chk({tag, " R1 strobes rd/wr/den/bhe"}, {rd_n, wr_n, den_n, bhe_n}, 4'hF);
    chk({tag, " R1 ad_oe/mio/dtr"}, {ad_oe, mio, dtr}, 0);
    chk({tag, " R1 addr_hi"}, addr_hi, 0);
    chk({tag, " R1 rsp_valid"}, rsp_valid, 0);
  endtask

  task automatic drive(input vec_t v);
    req_mem = v.mem; req_write = v.wr; req_bhe_n = v.bhe_n;
    req_addr = v.addr; req_wdata = v.wdata;
  endtask

  // data-phase checks shared by T2, T3 and Tw
  task automatic chk_strobe_ph(input vec_t v, input string ph);
    chk({ph, " R5 status"}, addr_hi, {2'b00, v.mem, v.wr});
    chk({ph, " R4 mio/dtr"}, {mio, dtr}, {v.mem, v.wr});
    chk({ph, " R10 req_ready low"}, req_ready, 0);
    chk({ph, " R2 bhe_n held"}, bhe_n, v.bhe_n);
    chk({ph, " R11 ale low"}, ale, 0);
    if (v.wr) begin
      chk({ph, " R7 ad_oe/ad_out"}, {ad_oe, ad_out}, {1'b1, v.wdata});
      chk({ph, " R7 wr_n/rd_n/den_n"}, {wr_n, rd_n, den_n}, 3'b010);
    end else begin
      chk({ph, " R6 ad_oe"}, ad_oe, 0);
      chk({ph, " R6 rd_n/wr_n/den_n"}, {rd_n, wr_n, den_n}, 3'b010);
    end
  endtask

  task automatic run_xfer(input vec_t v, input bit accepted, input bit chain,
                          input vec_t nxt, input bit poke);
    if (!accepted) begin
      @(negedge clk);
      drive(v); req_valid = 1'b1;
      @(posedge clk);
    end
    // T1
    @(negedge clk);
    if (poke) req_addr = v.addr ^ 20'h11111;
    else      req_valid = 1'b0;
    chk("T1 R2 ale", ale, 1);
    chk("T1 R2 ad_oe/ad_out", {ad_oe, ad_out}, {1'b1, v.addr[15:0]});
    chk("T1 R3 addr_hi", addr_hi, v.mem ? v.addr[19:16] : 4'h0);
    chk("T1 R3 mio", mio, v.mem);
    chk("T1 R4 dtr", dtr, v.wr);
    chk("T1 R2 bhe_n", bhe_n, v.bhe_n);
    chk("T1 R10 req_ready low", req_ready, 0);
    chk("T1 R2 strobes idle", {rd_n, wr_n, den_n}, 3'b111);
    @(posedge clk);
    @(negedge clk);
    chk_strobe_ph(v, "T2");
    @(posedge clk);
    @(negedge clk);
    chk_strobe_ph(v, "T3");
    ready = (v.nw == 0);
    ad_in = ready ? v.rdat : ~v.rdat;
    @(posedge clk);
    for (int w = 0; w < v.nw; w++) begin
      @(negedge clk);
      chk_strobe_ph(v, "Tw R8");
      chk("Tw R8 no rsp", rsp_valid, 0);
      ready = (w == v.nw - 1);
      ad_in = ready ? v.rdat : ~v.rdat;
      @(posedge clk);
    end
    // T4
    @(negedge clk);
    ready = 1'b1; ad_in = 16'h0;
    chk("T4 R9 rsp_valid", rsp_valid, 1);
    if (!v.wr) chk("T4 R9 rsp_rdata", rsp_rdata, v.rdat);
    chk("T4 R6/R7 rd_n/wr_n/den_n", {rd_n, wr_n, den_n}, 3'b110);
    chk("T4 R5 status", addr_hi, {2'b00, v.mem, v.wr});
    chk("T4 R4 mio/dtr", {mio, dtr}, {v.mem, v.wr});
    chk("T4 R6/R7 ad_oe", ad_oe, v.wr);
    if (v.wr) chk("T4 R7 ad_out", ad_out, v.wdata);
    chk("T4 R10 req_ready", req_ready, 1);
    if (chain) begin drive(nxt); req_valid = 1'b1; end
    else       req_valid = 1'b0;
    @(posedge clk);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      report();
    end
  end

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    chk_idle("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("after reset");

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      run_xfer(VECS[i], 1'b0, 1'b0, VECS[0], 1'b0);
      @(negedge clk);
      chk_idle("between");
    end

    // back-to-back: request accepted in T4 starts T1 next cycle
    run_xfer(VECS[1], 1'b0, 1'b1, VECS[2], 1'b0);
    run_xfer(VECS[2], 1'b1, 1'b1, VECS[3], 1'b0);
    run_xfer(VECS[3], 1'b1, 1'b0, VECS[0], 1'b0);

    // request held (with a changed address) while busy must not start anything
    run_xfer(VECS[4], 1'b0, 1'b0, VECS[0], 1'b1);
    @(negedge clk);
    chk("R10 no extra transfer", ale, 0);
    chk_idle("after held request");

    // reset in the middle of a write data phase
    @(negedge clk);
    drive(VECS[5]); req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("pre-reset R7 wr_n low", wr_n, 0);
    rst_n = 1'b0;
    #1;
    chk_idle("mid-cycle reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("after mid-cycle reset");

    finished = 1;
    report();
  end

endmodule